// File: doc/BRIEF.md
# Cache-Line Instruction Extractor

This block sits at the back end of an instruction fetch stage for one thread. When a 64-byte instruction cache line for the thread's current fetch PC is presented, it cuts a fetch group of up to `FETCH_W` 32-bit instructions out of the line. Each instruction goes toward decode with its own PC, its predicted next PC and a fresh sequence number. The block also advances the thread's fetch PC for the following cycle.

The group starts at the word that the fetch PC points to inside the line. It stops at the first of these: the end of the line, the width limit, a control instruction that the branch predictor calls taken, or a quiesce instruction. The slot PCs go out to an external predictor, which answers in the same cycle with a taken flag and a target for each slot. Per-word control and quiesce flags come from predecode alongside the line. A quiesce instruction puts the thread to sleep until it is redirected. A redirect loads a new fetch PC and wakes the thread.

Results are registered. A line sampled at a rising edge shows up on the slot outputs right after that edge, and the fetch PC moves at the same edge.

Top module: `fetch_line_extract`

## Requirements
- R1: After reset, `fetch_pc_o` equals `RESET_PC` (default 0), `fetch_npc_o` equals `RESET_PC`+4, `quiesced_o` is 0, `out_valid_o` is all zero and `out_count_o` is 0.
- R2: `fetch_addr_o` is `fetch_pc_o` with its low 6 bits cleared.
- R3: Line byte i sits at `line_data_i[8i+7:8i]`. Slot 0 takes the 32-bit word that starts at byte offset (`fetch_pc_o` mod 64) with the low 2 bits cleared. A word's lowest-addressed byte is its least significant byte. Slot k takes the word that follows slot k-1.
- R4: No slot takes a word beyond byte 63 of the line, so a group that starts at word w holds at most 16-w instructions.
- R5: A group holds at most `FETCH_W` (default 4) instructions.
- R6: Slot k has PC `fetch_pc_o`+4k. A slot whose word has `line_ctrl_i` bit 0 carries a predicted next PC of its own PC+4.
- R7: `bp_pc_o[k]` presents slot k's PC. A control slot (`line_ctrl_i` bit for its word = 1) with `bp_taken_i[k]`=1 carries `bp_target_i[k]` as its next PC and is the last slot of the group. With `bp_taken_i[k]`=0 its next PC is its PC+4 and the group goes on.
- R8: A quiesce slot (`line_quiesce_i` bit for its word = 1) is emitted and counted, ends the group and raises `quiesced_o`. While `quiesced_o` is 1, presented lines emit nothing and leave the fetch PC unchanged.
- R9: After a group, `fetch_pc_o` equals the last slot's next PC and `fetch_npc_o` equals that value +4. A cycle that emits nothing leaves both unchanged.
- R10: Emitted instructions carry sequence numbers that start at 0 after reset and rise by one for each instruction, across slots and across cycles.
- R11: `out_valid_o` is a contiguous run of ones from slot 0, and `out_count_o` equals the number of ones in it.
- R12: `redirect_i` loads `redirect_pc_i` into the fetch PC and clears `quiesced_o`. It takes priority over a line presented in the same cycle, which then emits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| redirect_i | input | 1 | Load a new fetch PC and wake the thread |
| redirect_pc_i | input | PC_W | New fetch PC |
| line_valid_i | input | 1 | A line for the current fetch PC is present |
| line_data_i | input | LINE_BYTES*8 | Line bytes, byte i at bits 8i+7:8i |
| line_ctrl_i | input | LINE_BYTES/4 | Per-word control-instruction flag |
| line_quiesce_i | input | LINE_BYTES/4 | Per-word quiesce flag |
| bp_taken_i | input | FETCH_W | Predictor taken flag per slot |
| bp_target_i | input | FETCH_W*PC_W | Predictor target per slot |
| bp_pc_o | output | FETCH_W*PC_W | Slot PCs presented to the predictor |
| fetch_addr_o | output | PC_W | Line-aligned request address |
| fetch_pc_o | output | PC_W | Current fetch PC |
| fetch_npc_o | output | PC_W | Current fetch PC plus 4 |
| quiesced_o | output | 1 | Thread is asleep after a quiesce |
| out_valid_o | output | FETCH_W | Per-slot valid |
| out_count_o | output | $clog2(FETCH_W+1) | Instructions emitted |
| out_inst_o | output | FETCH_W*32 | Instruction words |
| out_pc_o | output | FETCH_W*PC_W | Instruction PCs |
| out_npc_o | output | FETCH_W*PC_W | Predicted next PCs |
| out_seq_o | output | FETCH_W*SEQ_W | Sequence numbers |

## Verification
A wrong fetch PC shows up one edge later as a shifted word selection and wrong slot PCs, and a wrong group length shows up in the same cycle on the count and valid vector. The sequence counter and the quiesce flag carry errors forward: a skipped or repeated number is seen on the next emitting cycle, and a lost quiesce shows as emission where none is expected. The scenarios place the group start near the line end, put taken and not-taken control slots mid-group, and quiesce, then redirect while a line is still being presented.

// File: rtl/fle_pkg.sv
// Package: constants and the thread fetch state shared by the extractor.
// Assumes instructions are fixed 32-bit words.
package fle_pkg;
    localparam int INST_BYTES = 4;
    localparam int INST_W     = 8 * INST_BYTES;

    typedef enum logic {
        FL_RUN     = 1'b0,
        FL_ASLEEP  = 1'b1
    } fl_state_e;
endpackage

// File: rtl/fle_slot.sv
// One fetch slot: selects its word from the line, forms its PC and its
// predicted next PC, and reports whether it ends the group.
// Assumes FETCH_W <= words per line so one extra index bit suffices.
module fle_slot
    import fle_pkg::*;
#(
    parameter int SLOT       = 0,
    parameter int PC_W       = 32,
    parameter int LINE_BYTES = 64
) (
    input  logic [PC_W-1:0]              base_pc,
    input  logic [$clog2(LINE_BYTES/INST_BYTES)-1:0] word_off,
    input  logic [LINE_BYTES*8-1:0]      line_data,
    input  logic [LINE_BYTES/INST_BYTES-1:0] line_ctrl,
    input  logic [LINE_BYTES/INST_BYTES-1:0] line_quiesce,
    input  logic                         bp_taken,
    input  logic [PC_W-1:0]              bp_target,
    output logic [PC_W-1:0]              slot_pc,
    output logic [PC_W-1:0]              slot_npc,
    output logic [INST_W-1:0]            slot_inst,
    output logic                         in_line,
    output logic                         ends_group,
    output logic                         is_quiesce
);
    localparam int WORDS = LINE_BYTES / INST_BYTES;
    localparam int OFF_W = $clog2(WORDS);
    localparam int IDX_W = OFF_W + 1;

    logic [IDX_W-1:0] idx;
    logic [OFF_W-1:0] wsel;
    logic             ctrl;
    logic             taken_here;

    // Locate this slot's word and derive its fields.
    always_comb begin
        idx        = {1'b0, word_off} + IDX_W'(SLOT);
        wsel       = idx[OFF_W-1:0];
        in_line    = idx < IDX_W'(WORDS);
        slot_inst  = line_data[wsel*INST_W +: INST_W];
        ctrl       = line_ctrl[wsel];
        is_quiesce = line_quiesce[wsel];
        slot_pc    = base_pc + PC_W'(SLOT * INST_BYTES);
        taken_here = ctrl & bp_taken;
        slot_npc   = taken_here ? bp_target : (slot_pc + PC_W'(INST_BYTES));
        ends_group = taken_here | is_quiesce;
    end
endmodule

// File: rtl/fle_group.sv
// Group former: walks the slots in order and keeps each one while the
// previous one neither ended the group nor left the line. Produces the
// valid vector, the count, the last next PC and the quiesce hit.
// Assumes slot data arrive flattened, slot k at bits [k*PC_W +: PC_W].
module fle_group #(
    parameter int FETCH_W = 4,
    parameter int PC_W    = 32,
    localparam int CNT_W  = $clog2(FETCH_W + 1)
) (
    input  logic                    go,
    input  logic [PC_W-1:0]         cur_pc,
    input  logic [FETCH_W-1:0]      in_line,
    input  logic [FETCH_W-1:0]      ends,
    input  logic [FETCH_W-1:0]      is_q,
    input  logic [FETCH_W*PC_W-1:0] npc_flat,
    output logic [FETCH_W-1:0]      valid,
    output logic [CNT_W-1:0]        count,
    output logic [PC_W-1:0]         last_npc,
    output logic                    q_hit
);
    logic open;

    // Cut the group at the first terminating condition.
    always_comb begin
        open     = go;
        count    = '0;
        last_npc = cur_pc;
        q_hit    = 1'b0;
        for (int k = 0; k < FETCH_W; k++) begin
            valid[k] = open & in_line[k];
            if (valid[k]) begin
                count    = count + CNT_W'(1);
                last_npc = npc_flat[k*PC_W +: PC_W];
                q_hit    = q_hit | is_q[k];
            end
            open = valid[k] & ~ends[k];
        end
    end
endmodule

// File: rtl/fle_state.sv
// Thread state: fetch PC, its successor, the sequence counter and the
// run/asleep state. Redirect wins over group results.
module fle_state
    import fle_pkg::*;
#(
    parameter int              FETCH_W  = 4,
    parameter int              PC_W     = 32,
    parameter int              SEQ_W    = 16,
    parameter logic [PC_W-1:0] RESET_PC = '0,
    localparam int             CNT_W    = $clog2(FETCH_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              redirect,
    input  logic [PC_W-1:0]   redirect_pc,
    input  logic [CNT_W-1:0]  count,
    input  logic [PC_W-1:0]   last_npc,
    input  logic              q_hit,
    output logic [PC_W-1:0]   pc_q,
    output logic [PC_W-1:0]   npc_q,
    output logic [SEQ_W-1:0]  seq_q,
    output fl_state_e         state_q
);
    // Advance or reload the thread state once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= RESET_PC;
            npc_q   <= RESET_PC + PC_W'(INST_BYTES);
            seq_q   <= '0;
            state_q <= FL_RUN;
        end else if (redirect) begin
            pc_q    <= redirect_pc;
            npc_q   <= redirect_pc + PC_W'(INST_BYTES);
            state_q <= FL_RUN;
        end else begin
            if (count != '0) begin
                pc_q  <= last_npc;
                npc_q <= last_npc + PC_W'(INST_BYTES);
            end
            if (q_hit) begin
                state_q <= FL_ASLEEP;
            end
            seq_q <= seq_q + SEQ_W'(count);
        end
    end
endmodule

// File: rtl/fetch_line_extract.sv
// Top: extracts a fetch group from one instruction cache line for one
// thread, tags each instruction and registers the results toward decode.
// Assumes the presented line belongs to the current fetch PC and that the
// predictor answers combinationally for the slot PCs on bp_pc_o.
module fetch_line_extract
    import fle_pkg::*;
#(
    parameter int              FETCH_W    = 4,
    parameter int              PC_W       = 32,
    parameter int              SEQ_W      = 16,
    parameter int              LINE_BYTES = 64,
    parameter logic [PC_W-1:0] RESET_PC   = '0,
    localparam int             WORDS      = LINE_BYTES / INST_BYTES,
    localparam int             CNT_W      = $clog2(FETCH_W + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      redirect_i,
    input  logic [PC_W-1:0]           redirect_pc_i,
    input  logic                      line_valid_i,
    input  logic [LINE_BYTES*8-1:0]   line_data_i,
    input  logic [WORDS-1:0]          line_ctrl_i,
    input  logic [WORDS-1:0]          line_quiesce_i,
    input  logic [FETCH_W-1:0]        bp_taken_i,
    input  logic [FETCH_W*PC_W-1:0]   bp_target_i,
    output logic [FETCH_W*PC_W-1:0]   bp_pc_o,
    output logic [PC_W-1:0]           fetch_addr_o,
    output logic [PC_W-1:0]           fetch_pc_o,
    output logic [PC_W-1:0]           fetch_npc_o,
    output logic                      quiesced_o,
    output logic [FETCH_W-1:0]        out_valid_o,
    output logic [CNT_W-1:0]          out_count_o,
    output logic [FETCH_W*INST_W-1:0] out_inst_o,
    output logic [FETCH_W*PC_W-1:0]   out_pc_o,
    output logic [FETCH_W*PC_W-1:0]   out_npc_o,
    output logic [FETCH_W*SEQ_W-1:0]  out_seq_o
);
    localparam int ALIGN_W = $clog2(INST_BYTES);
    localparam int LINE_W  = $clog2(LINE_BYTES);

    logic [PC_W-1:0]           pc_q;
    logic [PC_W-1:0]           npc_q;
    logic [SEQ_W-1:0]          seq_q;
    fl_state_e                 state_q;
    logic                      go;
    logic [LINE_W-ALIGN_W-1:0] word_off;

    logic [FETCH_W*PC_W-1:0]   slot_pc_flat;
    logic [FETCH_W*PC_W-1:0]   slot_npc_flat;
    logic [FETCH_W*INST_W-1:0] slot_inst_flat;
    logic [FETCH_W-1:0]        in_line;
    logic [FETCH_W-1:0]        ends;
    logic [FETCH_W-1:0]        is_q;

    logic [FETCH_W-1:0]        valid;
    logic [CNT_W-1:0]          count;
    logic [PC_W-1:0]           last_npc;
    logic                      q_hit;

    // Fetch proceeds only for a running thread with no redirect pending.
    always_comb begin
        go       = line_valid_i & ~redirect_i & (state_q == FL_RUN);
        word_off = pc_q[LINE_W-1:ALIGN_W];
    end

    for (genvar k = 0; k < FETCH_W; k++) begin : g_slot
        fle_slot #(
            .SLOT       (k),
            .PC_W       (PC_W),
            .LINE_BYTES (LINE_BYTES)
        ) u_slot (
            .base_pc      (pc_q),
            .word_off     (word_off),
            .line_data    (line_data_i),
            .line_ctrl    (line_ctrl_i),
            .line_quiesce (line_quiesce_i),
            .bp_taken     (bp_taken_i[k]),
            .bp_target    (bp_target_i[k*PC_W +: PC_W]),
            .slot_pc      (slot_pc_flat[k*PC_W +: PC_W]),
            .slot_npc     (slot_npc_flat[k*PC_W +: PC_W]),
            .slot_inst    (slot_inst_flat[k*INST_W +: INST_W]),
            .in_line      (in_line[k]),
            .ends_group   (ends[k]),
            .is_quiesce   (is_q[k])
        );
    end

    fle_group #(
        .FETCH_W (FETCH_W),
        .PC_W    (PC_W)
    ) u_group (
        .go       (go),
        .cur_pc   (pc_q),
        .in_line  (in_line),
        .ends     (ends),
        .is_q     (is_q),
        .npc_flat (slot_npc_flat),
        .valid    (valid),
        .count    (count),
        .last_npc (last_npc),
        .q_hit    (q_hit)
    );

    fle_state #(
        .FETCH_W  (FETCH_W),
        .PC_W     (PC_W),
        .SEQ_W    (SEQ_W),
        .RESET_PC (RESET_PC)
    ) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .redirect    (redirect_i),
        .redirect_pc (redirect_pc_i),
        .count       (count),
        .last_npc    (last_npc),
        .q_hit       (q_hit),
        .pc_q        (pc_q),
        .npc_q       (npc_q),
        .seq_q       (seq_q),
        .state_q     (state_q)
    );

    // Register the group toward decode; fields load only for kept slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= '0;
            out_count_o <= '0;
            out_inst_o  <= '0;
            out_pc_o    <= '0;
            out_npc_o   <= '0;
            out_seq_o   <= '0;
        end else begin
            out_valid_o <= valid;
            out_count_o <= count;
            for (int k = 0; k < FETCH_W; k++) begin
                if (valid[k]) begin
                    out_inst_o[k*INST_W +: INST_W] <= slot_inst_flat[k*INST_W +: INST_W];
                    out_pc_o[k*PC_W +: PC_W]       <= slot_pc_flat[k*PC_W +: PC_W];
                    out_npc_o[k*PC_W +: PC_W]      <= slot_npc_flat[k*PC_W +: PC_W];
                    out_seq_o[k*SEQ_W +: SEQ_W]    <= seq_q + SEQ_W'(k);
                end
            end
        end
    end

    // Drive the thread-facing outputs from state.
    always_comb begin
        bp_pc_o      = slot_pc_flat;
        fetch_pc_o   = pc_q;
        fetch_npc_o  = npc_q;
        fetch_addr_o = {pc_q[PC_W-1:LINE_W], LINE_W'(0)};
        quiesced_o   = (state_q == FL_ASLEEP);
    end
endmodule

// File: rtl/fetch_line_extract_chk.sv
// Checker: port-level properties of the extractor, bound to the top.
module fetch_line_extract_chk #(
    parameter int FETCH_W = 4,
    parameter int PC_W    = 32,
    parameter int SEQ_W   = 16,
    localparam int CNT_W  = $clog2(FETCH_W + 1)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [FETCH_W-1:0]       out_valid_o,
    input logic [CNT_W-1:0]         out_count_o,
    input logic [FETCH_W*PC_W-1:0]  out_pc_o,
    input logic [FETCH_W*PC_W-1:0]  out_npc_o,
    input logic [FETCH_W*SEQ_W-1:0] out_seq_o,
    input logic [PC_W-1:0]          fetch_pc_o,
    input logic [PC_W-1:0]          fetch_npc_o,
    input logic                     quiesced_o
);
    logic [PC_W-1:0] chk_last_npc;

    // Next PC of the highest valid slot in the registered group.
    always_comb begin
        chk_last_npc = '0;
        for (int k = 0; k < FETCH_W; k++) begin
            if (out_valid_o[k]) chk_last_npc = out_npc_o[k*PC_W +: PC_W];
        end
    end

    a_r11_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(out_valid_o) == out_count_o);

    a_r9_npc_pair: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_npc_o == fetch_pc_o + PC_W'(4));

    a_r9_pc_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (out_count_o != '0) |-> (fetch_pc_o == chk_last_npc));

    a_r8_asleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        quiesced_o |=> (out_count_o == '0));

    a_r8_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(quiesced_o) |-> (out_count_o != '0));

    for (genvar k = 1; k < FETCH_W; k++) begin : g_pair
        a_r11_prefix: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid_o[k] |-> out_valid_o[k-1]);
        a_r6_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid_o[k] |-> (out_pc_o[k*PC_W +: PC_W] ==
                                out_pc_o[(k-1)*PC_W +: PC_W] + PC_W'(4)));
        a_r10_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid_o[k] |-> (out_seq_o[k*SEQ_W +: SEQ_W] ==
                                out_seq_o[(k-1)*SEQ_W +: SEQ_W] + SEQ_W'(1)));
    end
endmodule

bind fetch_line_extract fetch_line_extract_chk #(
    .FETCH_W (FETCH_W),
    .PC_W    (PC_W),
    .SEQ_W   (SEQ_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .out_valid_o (out_valid_o),
    .out_count_o (out_count_o),
    .out_pc_o    (out_pc_o),
    .out_npc_o   (out_npc_o),
    .out_seq_o   (out_seq_o),
    .fetch_pc_o  (fetch_pc_o),
    .fetch_npc_o (fetch_npc_o),
    .quiesced_o  (quiesced_o)
);

// File: tb/fetch_line_extract_tb.sv
// Scoreboard bench: the driver pushes the expected group per cycle, the
// monitor pops and compares after each rising edge.
module fetch_line_extract_tb;
    localparam int W  = 4;
    localparam int PW = 32;
    localparam int SW = 16;
    localparam int CW = 3;
    localparam int LB = 64;

    typedef struct packed {
        logic [CW-1:0]        cnt;
        logic [W-1:0]         vld;
        logic [W-1:0][31:0]   inst;
        logic [W-1:0][PW-1:0] pc;
        logic [W-1:0][PW-1:0] npc;
        logic [W-1:0][SW-1:0] seq;
        logic [PW-1:0]        fpc;
        logic                 q;
    } exp_t;

    logic            clk = 0;
    logic            rst_n = 0;
    logic            redirect_i = 0;
    logic [PW-1:0]   redirect_pc_i = '0;
    logic            line_valid_i = 0;
    logic [LB*8-1:0] line_data_i = '0;
    logic [15:0]     line_ctrl_i = '0;
    logic [15:0]     line_quiesce_i = '0;
    logic [W-1:0]    bp_taken_i = '0;
    logic [W*PW-1:0] bp_target_i = '0;
    logic [W*PW-1:0] bp_pc_o;
    logic [PW-1:0]   fetch_addr_o, fetch_pc_o, fetch_npc_o;
    logic            quiesced_o;
    logic [W-1:0]    out_valid_o;
    logic [CW-1:0]   out_count_o;
    logic [W*32-1:0] out_inst_o;
    logic [W*PW-1:0] out_pc_o, out_npc_o;
    logic [W*SW-1:0] out_seq_o;

    int errors = 0;
    int checks = 0;
    exp_t  exp_q[$];
    string tag_q[$];
    logic [PW-1:0] m_pc = '0;
    logic [SW-1:0] m_seq = '0;
    logic          m_q = 0;

    always #10 clk = ~clk;

    fetch_line_extract u_dut (
        .clk(clk), .rst_n(rst_n), .redirect_i(redirect_i),
        .redirect_pc_i(redirect_pc_i), .line_valid_i(line_valid_i),
        .line_data_i(line_data_i), .line_ctrl_i(line_ctrl_i),
        .line_quiesce_i(line_quiesce_i), .bp_taken_i(bp_taken_i),
        .bp_target_i(bp_target_i), .bp_pc_o(bp_pc_o),
        .fetch_addr_o(fetch_addr_o), .fetch_pc_o(fetch_pc_o),
        .fetch_npc_o(fetch_npc_o), .quiesced_o(quiesced_o),
        .out_valid_o(out_valid_o), .out_count_o(out_count_o),
        .out_inst_o(out_inst_o), .out_pc_o(out_pc_o),
        .out_npc_o(out_npc_o), .out_seq_o(out_seq_o)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [7:0] bval(input int seed, input int i);
        return 8'((seed * 37 + i * 11 + 3) & 255);
    endfunction

    // Drive one cycle and push the outcome the requirements predict.
    task automatic drive(input string tag, input bit redir, input logic [PW-1:0] rpc,
                         input bit lv, input int seed, input logic [15:0] ctrl,
                         input logic [15:0] qm, input logic [W-1:0] tk,
                         input logic [PW-1:0] tgt);
        exp_t e;
        logic [PW-1:0] last;
        @(negedge clk);
        redirect_i = redir; redirect_pc_i = rpc; line_valid_i = lv;
        for (int i = 0; i < LB; i++) line_data_i[8*i +: 8] = bval(seed, i);
        line_ctrl_i = ctrl; line_quiesce_i = qm; bp_taken_i = tk;
        for (int k = 0; k < W; k++) bp_target_i[k*PW +: PW] = tgt;
        e = '0;
        last = m_pc;
        if (redir) begin
            m_pc = rpc; m_q = 0;
        end else if (lv && !m_q) begin
            for (int k = 0; k < W; k++) begin
                int idx;
                logic [PW-1:0] p, np;
                bit c;
                idx = int'(m_pc[5:2]) + k;
                if (idx > 15) break;
                p = m_pc + PW'(4 * k);
                c = ctrl[idx];
                np = (c && tk[k]) ? tgt : p + 32'd4;
                e.vld[k] = 1'b1;
                e.cnt = e.cnt + 1'b1;
                e.inst[k] = {bval(seed, 4*idx+3), bval(seed, 4*idx+2),
                             bval(seed, 4*idx+1), bval(seed, 4*idx)};
                e.pc[k] = p; e.npc[k] = np;
                e.seq[k] = m_seq + SW'(k);
                last = np;
                if (c && tk[k]) break;
                if (qm[idx]) begin m_q = 1; break; end
            end
            m_pc = last;
            m_seq = m_seq + SW'(e.cnt);
        end
        e.fpc = m_pc; e.q = m_q;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare the outputs a little after each rising edge.
    always @(posedge clk) begin
        #5;
        if (exp_q.size() > 0) begin
            exp_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(out_count_o == e.cnt, {t, " count"}, 64'(out_count_o), 64'(e.cnt));
            chk(out_valid_o == e.vld, "R11 valid vector", 64'(out_valid_o), 64'(e.vld));
            for (int k = 0; k < W; k++) begin
                if (e.vld[k]) begin
                    chk(out_inst_o[32*k +: 32] == e.inst[k], "R3 word",
                        64'(out_inst_o[32*k +: 32]), 64'(e.inst[k]));
                    chk(out_pc_o[PW*k +: PW] == e.pc[k], "R6 slot pc",
                        64'(out_pc_o[PW*k +: PW]), 64'(e.pc[k]));
                    chk(out_npc_o[PW*k +: PW] == e.npc[k], {t, " slot next pc"},
                        64'(out_npc_o[PW*k +: PW]), 64'(e.npc[k]));
                    chk(out_seq_o[SW*k +: SW] == e.seq[k], "R10 sequence",
                        64'(out_seq_o[SW*k +: SW]), 64'(e.seq[k]));
                end
            end
            chk(fetch_pc_o == e.fpc, "R9 fetch pc", 64'(fetch_pc_o), 64'(e.fpc));
            chk(fetch_npc_o == e.fpc + 32'd4, "R9 fetch npc", 64'(fetch_npc_o), 64'(e.fpc + 32'd4));
            chk(quiesced_o == e.q, "R8 quiesced", 64'(quiesced_o), 64'(e.q));
            chk(fetch_addr_o == {e.fpc[PW-1:6], 6'b0}, "R2 request address",
                64'(fetch_addr_o), 64'({e.fpc[PW-1:6], 6'b0}));
        end
    end

    initial begin : wdog
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #5;
        chk(fetch_pc_o == 32'h0, "R1 reset pc", 64'(fetch_pc_o), 64'h0);
        chk(fetch_npc_o == 32'h4, "R1 reset npc", 64'(fetch_npc_o), 64'h4);
        chk(quiesced_o == 1'b0, "R1 reset quiesced", 64'(quiesced_o), 64'h0);
        chk(out_valid_o == '0 && out_count_o == '0, "R1 reset outputs",
            64'(out_count_o), 64'h0);
        @(negedge clk);
        rst_n = 1;
        // R12: redirect to a line start.
        drive("R12", 1, 32'h1000, 0, 0, 16'h0, 16'h0, 4'h0, 32'h0);
        // R5: plain line, group capped by width.
        drive("R5", 0, 32'h0, 1, 1, 16'h0, 16'h0, 4'h0, 32'h0);
        // R4: start at word 13, group capped by line end.
        drive("R12", 1, 32'h1034, 0, 0, 16'h0, 16'h0, 4'h0, 32'h0);
        drive("R4", 0, 32'h0, 1, 2, 16'h0, 16'h0, 4'h0, 32'h0);
        // R7: not-taken control at slot 1, taken control at slot 2.
        drive("R12", 1, 32'h3000, 0, 0, 16'h0, 16'h0, 4'h0, 32'h0);
        drive("R7", 0, 32'h0, 1, 3, 16'h0006, 16'h0, 4'b0110 & 4'b0100, 32'h3800);
        // R7: taken control at slot 0 into the tail of a line.
        drive("R7", 0, 32'h0, 1, 4, 16'h0001, 16'h0, 4'b0001, 32'h5038);
        drive("R4", 0, 32'h0, 1, 5, 16'h0, 16'h0, 4'h0, 32'h0);
        // R9: no line presented, nothing moves.
        drive("R9", 0, 32'h0, 0, 0, 16'h0, 16'h0, 4'h0, 32'h0);
        // R8: quiesce at slot 1, then a presented line is ignored.
        drive("R12", 1, 32'h4000, 0, 0, 16'h0, 16'h0, 4'h0, 32'h0);
        drive("R8", 0, 32'h0, 1, 6, 16'h0, 16'h0002, 4'h0, 32'h0);
        drive("R8", 0, 32'h0, 1, 7, 16'h0, 16'h0, 4'h0, 32'h0);
        // R12: redirect wins over a presented line and wakes the thread.
        drive("R12", 1, 32'h4040, 1, 8, 16'h0, 16'h0, 4'h0, 32'h0);
        drive("R10", 0, 32'h0, 1, 9, 16'h0, 16'h0, 4'h0, 32'h0);
        drive("R9", 0, 32'h0, 0, 0, 16'h0, 16'h0, 4'h0, 32'h0);
        repeat (3) @(posedge clk);
        #7;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule